// File: doc/BRIEF.md
# Serial successive-approximation converter controller

This block is the digital half of an 8-bit successive-approximation converter with a three-wire synchronous serial port. A host pulls the active-low select low and toggles the serial clock. The block ignores zeros on the serial input until it sees a start bit, then reads a two-bit channel assignment word. It allows half a clock for the analog multiplexer to settle and then runs eight compare steps against an external DAC and comparator. Each decision appears on the serial output as soon as it is made, most significant bit first. The finished word is then sent a second time, least significant bit first, and after that the output holds low.

While select is high the output is tri-stated and the low-power flag is raised. Raising select at any point aborts the transaction. Because the serial input is only read before the output is enabled, the input and output wires can share one bidirectional host pin. A build parameter selects a single-channel variant. That variant has no address word and no reversed replay.

The sequencer states are IDLE, HUNT, ADDR, SETTLE, CONV, REPLAY and TAIL. The transitions are:
- IDLE→HUNT when a zero is sampled.
- IDLE or HUNT→ADDR when a one is sampled (→SETTLE in the single-channel variant).
- ADDR→SETTLE after the second address bit.
- SETTLE→CONV after one clock.
- CONV→REPLAY after the eighth step (→TAIL in the single-channel variant).
- REPLAY→TAIL after eight bits.
- TAIL holds.
- Any state→IDLE when select rises or reset is applied.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While `cs_n` is high, `sdo_en` is 0 and `low_power` is 1. Raising `cs_n` at any time ends the transaction at once, and the next transaction behaves as if from idle.
- R2: `sdi` is sampled on rising `sclk` edges. Any number of leading zeros is ignored, and the first 1 is the start bit.
- R3: The two bits after the start bit form the assignment word, sent bit1 first. Bit1=1 selects single-ended mode (`diff_mode`=0) and bit1=0 selects differential mode (`diff_mode`=1). Bit0 drives `chan_sel`, which is the channel on the plus side. Both outputs change only on the edge that samples the last address bit, and they reset to 0.
- R4: On the falling edge after the last address bit, `sdo_en` rises and `sdo` is 0 for that clock.
- R5: `sdi` has no effect on the result or on `sdo` from the settling clock until `cs_n` rises.
- R6: Conversion step k (k=0..7) presents the decided bits plus a 1 at bit 7-k on `dac_code`, with the lower bits 0. `cmp_gt` is sampled on the falling edge, and the bit is kept when `cmp_gt` is 1. An input whose plus side is below its minus side therefore converts to 0x00.
- R7: Each decision appears on `sdo` at the falling edge of its step, most significant bit first.
- R8: After the eighth decision, all eight result bits are sent again, least significant bit first, one per falling edge.
- R9: After the replay, `sdo` is 0 with `sdo_en` 1 until `cs_n` rises.
- R10: With `SINGLE_CH`=1, no address word is read: the clock after the start bit is the settling clock. After the most-significant-first stream, `sdo` goes straight to 0. The channel outputs are fixed at `chan_sel`=0 and `diff_mode`=1.
- R11: `dac_code` is 0 outside the conversion steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; high aborts the transaction and idles the block |
| sdi | input | 1 | Serial data in, sampled on rising edges |
| cmp_gt | input | 1 | Comparator decision: input above trial level |
| sdo | output | 1 | Serial data out, changes on falling edges |
| sdo_en | output | 1 | Output enable for the tri-state driver of `sdo` |
| dac_code | output | 8 | Trial code for the external DAC |
| chan_sel | output | 1 | Channel on the plus side of the multiplexer |
| diff_mode | output | 1 | 1 = differential pair, 0 = single-ended to ground |
| low_power | output | 1 | Low-power indication, high while deselected |

## Verification
The assertions take for granted that the comparator settles within half a clock after `dac_code` changes. They also assume that `cs_n` and `sdi` change only while the clock is low, away from both edges. The bench's behavioural comparator is combinational on `dac_code` and the channel outputs. All stimulus is driven one time unit after a falling edge, which keeps the bench within both assumptions. The bench also drives random data on `sdi` throughout the conversion and replay, to show that the input is ignored there.

// File: rtl/sar_ser_pkg.sv
`timescale 1ns/1ps
package sar_ser_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ADDR,
        ST_SETTLE,
        ST_CONV,
        ST_REPLAY,
        ST_TAIL
    } seq_state_t;
endpackage

// File: rtl/sar_seq_fsm.sv
`timescale 1ns/1ps
module sar_seq_fsm
    import sar_ser_pkg::*;
#(
    parameter int RES_BITS  = 8,
    parameter bit SINGLE_CH = 1'b0,
    localparam int CNT_W    = $clog2(RES_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             di,
    output seq_state_t       state,
    output logic [CNT_W-1:0] step,
    output logic             chan_sel,
    output logic             diff_mode
);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(RES_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);

    seq_state_t       nxt_state;
    logic [CNT_W-1:0] nxt_step;
    logic             addr_first;
    logic             addr_fire;

    assign addr_fire = (state == ST_ADDR) && (step == ADDR_LAST);

    // state register
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= nxt_state;
            step  <= nxt_step;
        end
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_step  = '0;
        unique case (state)
            ST_IDLE, ST_HUNT: begin
                if (di) nxt_state = SINGLE_CH ? ST_SETTLE : ST_ADDR;
                else    nxt_state = ST_HUNT;
            end
            ST_ADDR: begin
                if (step == ADDR_LAST) nxt_state = ST_SETTLE;
                else                   nxt_step  = step + 1'b1;
            end
            ST_SETTLE: nxt_state = ST_CONV;
            ST_CONV: begin
                if (step == LAST_STEP) nxt_state = SINGLE_CH ? ST_TAIL : ST_REPLAY;
                else                   nxt_step  = step + 1'b1;
            end
            ST_REPLAY: begin
                if (step == LAST_STEP) nxt_state = ST_TAIL;
                else                   nxt_step  = step + 1'b1;
            end
            ST_TAIL:  nxt_state = ST_TAIL;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // first address bit holding register
    always_ff @(posedge clk or posedge clr) begin
        if (clr)                                   addr_first <= 1'b0;
        else if (state == ST_ADDR && !addr_fire)   addr_first <= di;
    end

    generate
        if (SINGLE_CH) begin : g_fixed_chan
            assign chan_sel  = 1'b0;
            assign diff_mode = 1'b1;
        end else begin : g_addr_chan
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chan_sel  <= 1'b0;
                    diff_mode <= 1'b0;
                end else if (addr_fire) begin
                    diff_mode <= ~addr_first;
                    chan_sel  <= di;
                end
            end
        end
    endgenerate

    // R4
    settle_to_conv_chk: assert property (@(posedge clk) disable iff (clr)
        state == ST_SETTLE |=> state == ST_CONV);

    // R6
    conv_continue_chk: assert property (@(posedge clk) disable iff (clr)
        (state == ST_CONV && step != LAST_STEP) |=> state == ST_CONV);

    // R3
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_fire |=> $stable({chan_sel, diff_mode}));

    // R10
    single_path_chk: assert property (@(posedge clk) disable iff (clr)
        SINGLE_CH |-> (state != ST_ADDR && state != ST_REPLAY));
endmodule

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
module sar_trial_reg #(
    parameter int RES_BITS = 8,
    localparam int CNT_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                load,
    input  logic                conv,
    input  logic [CNT_W-1:0]    step,
    input  logic                dec,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result
);
    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(RES_BITS - 1);

    logic [CNT_W-1:0]    bit_idx;
    logic [RES_BITS-1:0] trial_bit;

    assign bit_idx   = TOP_IDX - step;
    assign trial_bit = {{(RES_BITS-1){1'b0}}, 1'b1} << bit_idx;
    assign dac_code  = conv ? (result | trial_bit) : '0;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)       result <= '0;
        else if (load) result <= '0;
        else if (conv) result[bit_idx] <= dec;
    end

    // R6
    trial_msb_chk: assert property (@(posedge clk) disable iff (clr)
        load |=> dac_code == {1'b1, {(RES_BITS-1){1'b0}}});

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (!conv && !load) |=> $stable(result));
endmodule

// File: rtl/sar_dout_drv.sv
`timescale 1ns/1ps
module sar_dout_drv
    import sar_ser_pkg::*;
#(
    parameter int RES_BITS = 8,
    localparam int CNT_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  seq_state_t          state,
    input  logic [CNT_W-1:0]    step,
    input  logic                cmp_gt,
    input  logic [RES_BITS-1:0] result,
    output logic                dec,
    output logic                sdo,
    output logic                sdo_en
);
    // output register, updated on falling edges
    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
            dec    <= 1'b0;
        end else begin
            unique case (state)
                ST_SETTLE: begin
                    sdo_en <= 1'b1;
                    sdo    <= 1'b0;
                end
                ST_CONV: begin
                    sdo_en <= 1'b1;
                    sdo    <= cmp_gt;
                    dec    <= cmp_gt;
                end
                ST_REPLAY: begin
                    sdo_en <= 1'b1;
                    sdo    <= result[step];
                end
                ST_TAIL: begin
                    sdo_en <= 1'b1;
                    sdo    <= 1'b0;
                end
                default: begin
                    sdo_en <= 1'b0;
                    sdo    <= 1'b0;
                end
            endcase
        end
    end

    // R1
    idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !sdo_en);

    // R4
    settle_zero_chk: assert property (@(posedge clk) disable iff (clr)
        state == ST_SETTLE |-> (sdo_en && !sdo));

    // R9
    tail_low_chk: assert property (@(posedge clk) disable iff (clr)
        state == ST_TAIL |-> (sdo_en && !sdo));
endmodule

// File: rtl/sar_serial_ctrl.sv
`timescale 1ns/1ps
module sar_serial_ctrl
    import sar_ser_pkg::*;
#(
    parameter int RES_BITS  = 8,
    parameter bit SINGLE_CH = 1'b0
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sdi,
    input  logic                cmp_gt,
    output logic                sdo,
    output logic                sdo_en,
    output logic [RES_BITS-1:0] dac_code,
    output logic                chan_sel,
    output logic                diff_mode,
    output logic                low_power
);
    localparam int CNT_W = $clog2(RES_BITS);

    seq_state_t          state;
    logic [CNT_W-1:0]    step;
    logic [RES_BITS-1:0] result;
    logic                dec;
    logic                clr;

    assign clr       = cs_n | ~rst_n;
    assign low_power = cs_n;

    sar_seq_fsm #(.RES_BITS(RES_BITS), .SINGLE_CH(SINGLE_CH)) fsm_i (
        .clk(sclk), .rst_n(rst_n), .clr(clr), .di(sdi),
        .state(state), .step(step), .chan_sel(chan_sel), .diff_mode(diff_mode)
    );

    sar_trial_reg #(.RES_BITS(RES_BITS)) trial_i (
        .clk(sclk), .clr(clr),
        .load(state == ST_SETTLE), .conv(state == ST_CONV),
        .step(step), .dec(dec), .dac_code(dac_code), .result(result)
    );

    sar_dout_drv #(.RES_BITS(RES_BITS)) dout_i (
        .clk(sclk), .rst_n(rst_n), .clr(clr), .state(state), .step(step),
        .cmp_gt(cmp_gt), .result(result), .dec(dec), .sdo(sdo), .sdo_en(sdo_en)
    );

    // R11
    dac_idle_chk: assert property (@(posedge sclk) disable iff (clr)
        (state == ST_TAIL || state == ST_REPLAY) |-> dac_code == '0);
endmodule

// File: tb/sar_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_serial_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sdi = 1'b0;
    logic cs2_n = 1'b1, sdi2 = 1'b0;
    logic cmp_a, cmp_b;
    logic sdo_a, en_a, chan_a, diff_a, lp_a;
    logic sdo_b, en_b, chan_b, diff_b, lp_b;
    logic [7:0] dac_a, dac_b;
    int ch0 = 0, ch1 = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sar_serial_ctrl dut_i (
        .sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .cmp_gt(cmp_a),
        .sdo(sdo_a), .sdo_en(en_a), .dac_code(dac_a),
        .chan_sel(chan_a), .diff_mode(diff_a), .low_power(lp_a));

    sar_serial_ctrl #(.SINGLE_CH(1'b1)) dut_sc_i (
        .sclk(clk), .rst_n(rst_n), .cs_n(cs2_n), .sdi(sdi2), .cmp_gt(cmp_b),
        .sdo(sdo_b), .sdo_en(en_b), .dac_code(dac_b),
        .chan_sel(chan_b), .diff_mode(diff_b), .low_power(lp_b));

    // behavioural analog mux + comparator, input at code+1/2 LSB
    always_comb begin
        int p, m;
        p = chan_a ? ch1 : ch0;
        m = diff_a ? (chan_a ? ch0 : ch1) : 0;
        cmp_a = (2 * (p - m) + 1) > 2 * int'(dac_a);
        cmp_b = (2 * (ch0 - ch1) + 1) > 2 * int'(dac_b);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_a(input logic d);
        sdi = d; @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic bit_b(input logic d);
        sdi2 = d; @(posedge clk); @(negedge clk); #1;
    endtask

    function automatic int expect_code(input logic [1:0] a);
        int p, m;
        p = a[0] ? ch1 : ch0;
        m = a[1] ? 0 : (a[0] ? ch0 : ch1);
        return (p > m) ? p - m : 0;
    endfunction

    task automatic xact(input int lead, input logic [1:0] a, input int abort_after);
        logic [7:0] msb, lsb;
        logic c0, d0;
        int exp;
        msb = '0; lsb = '0;
        exp = expect_code(a);
        c0 = chan_a; d0 = diff_a;
        cs_n = 1'b0;
        for (int i = 0; i < lead; i++) begin
            bit_a(1'b0);
            // R2
            chk(!en_a, "R2 leading zero ignored", en_a, 0);
        end
        bit_a(1'b1);
        bit_a(a[1]);
        // R3 outputs hold until last address bit
        chk(chan_a == c0 && diff_a == d0, "R3 hold before last bit", {chan_a, diff_a}, {c0, d0});
        bit_a(a[0]);
        // R3
        chk(chan_a == a[0] && diff_a == !a[1], "R3 address decode", {chan_a, diff_a}, {a[0], !a[1]});
        // R4
        chk(en_a && !sdo_a, "R4 settle zero", {en_a, sdo_a}, 2'b10);
        for (int i = 0; i < 8; i++) begin
            bit_a(1'($urandom_range(1)));   // R5 noise on input
            msb[7 - i] = sdo_a;
            if (abort_after == i) begin
                cs_n = 1'b1; #1;
                // R1
                chk(!en_a && lp_a, "R1 abort tristate", {en_a, lp_a}, 2'b01);
                bit_a(1'b0); bit_a(1'b0);
                chk(!en_a && dac_a == 0, "R1 abort idle", {en_a, dac_a}, 0);
                return;
            end
        end
        // R6 R7 R5
        chk(msb == exp[7:0], "R7 msb stream", msb, exp);
        for (int i = 0; i < 8; i++) begin
            bit_a(1'($urandom_range(1)));
            lsb[i] = sdo_a;
        end
        // R8
        chk(lsb == exp[7:0], "R8 lsb replay", lsb, exp);
        for (int i = 0; i < 3; i++) begin
            bit_a(1'($urandom_range(1)));
            // R9 R11
            chk(en_a && !sdo_a && dac_a == 0, "R9 tail low", {en_a, sdo_a, dac_a}, 10'h200);
        end
        cs_n = 1'b1; #1;
        // R1
        chk(!en_a && lp_a, "R1 deselect", {en_a, lp_a}, 2'b01);
        bit_a(1'b0);
    endtask

    task automatic xact_sc(input int lead);
        logic [7:0] msb;
        int exp;
        exp = (ch0 > ch1) ? ch0 - ch1 : 0;
        cs2_n = 1'b0;
        for (int i = 0; i < lead; i++) bit_b(1'b0);
        bit_b(1'b1);
        // R10 settle right after start bit
        chk(en_b && !sdo_b && chan_b == 0 && diff_b, "R10 settle no address",
            {en_b, sdo_b, chan_b, diff_b}, 4'b1001);
        for (int i = 0; i < 8; i++) begin
            bit_b(1'($urandom_range(1)));
            msb[7 - i] = sdo_b;
        end
        chk(msb == exp[7:0], "R10 msb stream", msb, exp);
        for (int i = 0; i < 3; i++) begin
            bit_b(1'($urandom_range(1)));
            chk(en_b && !sdo_b, "R10 no replay", {en_b, sdo_b}, 2'b10);
        end
        cs2_n = 1'b1;
        bit_b(1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 R3 R11 reset state
        chk(!en_a && lp_a && dac_a == 0 && !chan_a && !diff_a, "R1 reset state",
            {en_a, lp_a, dac_a, chan_a, diff_a}, 12'h400);
        rst_n = 1'b1;
        bit_a(1'b0);
        // R6 single-ended sweep of every code on channel 0
        ch1 = 77;
        for (int v = 0; v < 256; v++) begin
            ch0 = v;
            xact(v % 4, 2'b10, -1);
        end
        // single-ended channel 1
        for (int v = 0; v < 256; v += 15) begin
            ch1 = v; ch0 = 255 - v;
            xact(1, 2'b11, -1);
        end
        // R6 differential both polarities, including negative inputs
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 23) begin
                ch0 = a; ch1 = b;
                xact(0, 2'b00, -1);
                xact(2, 2'b01, -1);
            end
        end
        // R1 abort at several points, then a clean transaction
        for (int k = 0; k < 8; k += 3) begin
            ch0 = 200; ch1 = 10;
            xact(1, 2'b10, k);
            xact(0, 2'b00, -1);
        end
        // R10 single-channel build
        for (int v = 0; v < 256; v += 9) begin
            ch0 = v; ch1 = 40;
            xact_sc(v % 3);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule